// File: doc/BRIEF.md
# TCP Session Payload Tap

This block sits on a receive path that carries raw Ethernet II frames one byte per clock. It follows exactly one TCP connection, chosen by four configuration inputs: source IPv4 address, destination IPv4 address, source port and destination port. Each frame is parsed as it streams past, through the MAC header, the IPv4 header and the TCP header. For a segment of the selected connection, the block marks every TCP payload byte with a valid strobe. All other bytes are discarded without any indication.

The block only observes the stream. It never drives a transmit path, never sends acknowledgements and never holds the stream back, so it can take a new byte on every clock at line rate. As an option, it compares each segment's sequence number with the sequence number expected from the previous complete segment. A segment that fails this comparison is dropped, so a retransmitted duplicate is not delivered twice. Each output byte appears one clock after the input byte that carried it.

Top module: `tcp_session_tap`

## Requirements
- R1: While reset is held, and after it is released, `out_valid` stays low until a matching payload byte arrives.
- R2: For a matching segment, each TCP payload byte is presented on `out_data`, with `out_valid` high, in the clock after it was accepted, in input order. Header bytes, and the start-of-frame byte, never raise `out_valid`.
- R3: A frame is parsed further only if frame bytes 12 and 13, read big-endian, equal 0x0800. Byte offsets count from the start-of-frame byte at 0.
- R4: Byte 14 must carry version 4 in its upper nibble and a header length of at least 5 words in its lower nibble. Byte 23 (the protocol field) must equal 6. The TCP header begins at 14 + 4 × header length, so IPv4 options are skipped.
- R5: Source IP (bytes 26–29), destination IP (bytes 30–33), and source and destination ports (TCP header bytes 0–3) must all equal the configured values, compared big-endian. Any single difference suppresses the whole frame, and so does the reversed direction.
- R6: The payload starts at TCP header start + 4 × the upper nibble of TCP header byte 12. TCP options are skipped, and a data offset below 5 drops the frame.
- R7: The payload ends at byte 14 + IPv4 total length (bytes 16–17). Ethernet padding after that point is never output.
- R8: An end-of-frame marker that arrives before the last header byte aborts the frame with no output. The aborted frame does not change the expected sequence number, and the next frame is parsed normally.
- R9: Every complete matching segment sets the expected sequence number to its sequence number (TCP bytes 4–7) plus its payload length. When `cfg_seq_chk` is 1, a segment whose sequence number differs from the expected value is dropped entirely. When `cfg_seq_chk` is 0, segments are delivered whatever their sequence number.
- R10: A start-of-frame marker that arrives in the middle of a frame restarts parsing at byte 0.
- R11: Cycles with `in_valid` low do not advance the byte position, and they produce no output in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_src_ip | input | 32 | Source IPv4 address of the followed connection |
| cfg_dst_ip | input | 32 | Destination IPv4 address of the followed connection |
| cfg_src_port | input | 16 | Source TCP port |
| cfg_dst_port | input | 16 | Destination TCP port |
| cfg_seq_chk | input | 1 | Drop segments whose sequence number is out of order |
| in_valid | input | 1 | A frame byte is present this cycle |
| in_byte | input | 8 | Frame byte |
| in_sof | input | 1 | This byte is the first of a frame |
| in_eof | input | 1 | This byte is the last of a frame |
| out_valid | output | 1 | `out_data` holds a payload byte of the followed connection |
| out_data | output | 8 | Payload byte |

## Verification
The clock that carries a segment's last payload byte with its end-of-frame marker is also the clock in which the expected sequence number is updated. The bench sends frames back to back so that the next frame's start-of-frame arrives in the very next clock. It also sends an aborted frame followed by a retransmission. A scoreboard receives the payload bytes that should appear and compares them with what appears. A frame that is wrongly accepted or wrongly dropped shows up either as an unexpected byte or as bytes left over in the queue.

// File: rtl/tcp_session_tap.sv
module tcp_session_tap #(
  parameter int IDX_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] cfg_src_ip,
  input  logic [31:0] cfg_dst_ip,
  input  logic [15:0] cfg_src_port,
  input  logic [15:0] cfg_dst_port,
  input  logic        cfg_seq_chk,
  input  logic        in_valid,
  input  logic [7:0]  in_byte,
  input  logic        in_sof,
  input  logic        in_eof,
  output logic        out_valid,
  output logic [7:0]  out_data
);
  localparam logic [IDX_W-1:0] MAC_LEN   = IDX_W'(14);
  localparam logic [IDX_W-1:0] AT_ETYPE  = IDX_W'(13);
  localparam logic [IDX_W-1:0] AT_VER    = IDX_W'(14);
  localparam logic [IDX_W-1:0] AT_TLEN   = IDX_W'(17);
  localparam logic [IDX_W-1:0] AT_PROTO  = IDX_W'(23);
  localparam logic [IDX_W-1:0] AT_SIP    = IDX_W'(29);
  localparam logic [IDX_W-1:0] AT_DIP    = IDX_W'(33);
  localparam logic [IDX_W-1:0] TCP_DFLT  = IDX_W'(34);
  localparam logic [IDX_W-1:0] ONE       = IDX_W'(1);

  logic [IDX_W-1:0] idx_q, cur_idx, tcp_start, pay_start, pay_end;
  logic [IDX_W-1:0] at_ports, at_seq, at_doff, new_start;
  logic             live_q, live_now, hdr_ok, seen_q, bad, pay_ok, done;
  logic [23:0]      sh_q;
  logic [31:0]      cur4, seg_seq, exp_seq;

  assign cur_idx   = in_sof ? '0 : idx_q;
  assign live_now  = in_sof | live_q;
  assign cur4      = {sh_q, in_byte};
  assign at_ports  = tcp_start + IDX_W'(3);
  assign at_seq    = tcp_start + IDX_W'(7);
  assign at_doff   = tcp_start + IDX_W'(12);
  assign new_start = tcp_start + IDX_W'({in_byte[7:4], 2'b00});

  always_comb begin
    bad = 1'b0;
    if (cur_idx == AT_ETYPE && cur4[15:0] != 16'h0800) bad = 1'b1;
    if (cur_idx == AT_VER && (in_byte[7:4] != 4'd4 || in_byte[3:0] < 4'd5)) bad = 1'b1;
    if (cur_idx == AT_PROTO && in_byte != 8'd6) bad = 1'b1;
    if (cur_idx == AT_SIP && cur4 != cfg_src_ip) bad = 1'b1;
    if (cur_idx == AT_DIP && cur4 != cfg_dst_ip) bad = 1'b1;
    if (cur_idx == at_ports && cur4 != {cfg_src_port, cfg_dst_port}) bad = 1'b1;
    if (cur_idx == at_seq && cfg_seq_chk && seen_q && cur4 != exp_seq) bad = 1'b1;
    if (cur_idx == at_doff && (in_byte[7:4] < 4'd5 || new_start > pay_end)) bad = 1'b1;
  end

  assign pay_ok = live_q && !in_sof && hdr_ok &&
                  cur_idx >= pay_start && cur_idx < pay_end;
  assign done   = in_eof && live_now && !bad && hdr_ok &&
                  (cur_idx + ONE) >= pay_start;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q     <= '0;
      live_q    <= 1'b0;
      hdr_ok    <= 1'b0;
      seen_q    <= 1'b0;
      sh_q      <= '0;
      tcp_start <= TCP_DFLT;
      pay_start <= '1;
      pay_end   <= '0;
      seg_seq   <= '0;
      exp_seq   <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid && pay_ok;
      if (in_valid) begin
        out_data <= in_byte;
        sh_q     <= cur4[23:0];
        idx_q    <= (cur_idx == '1) ? cur_idx : cur_idx + ONE;
        live_q   <= live_now && !bad && !in_eof;
        if (in_sof) hdr_ok <= 1'b0;
        if (cur_idx == AT_VER) tcp_start <= MAC_LEN + IDX_W'({in_byte[3:0], 2'b00});
        if (cur_idx == AT_TLEN) pay_end <= MAC_LEN + IDX_W'(cur4[15:0]);
        if (cur_idx == at_seq) seg_seq <= cur4;
        if (cur_idx == at_doff) begin
          pay_start <= new_start;
          hdr_ok    <= live_now && !bad;
        end
        if (done) begin
          exp_seq <= seg_seq + 32'(pay_end - pay_start);
          seen_q  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tcp_session_tap_chk.sv
module tcp_session_tap_chk (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_sof,
  input logic out_valid,
  input logic hdr_ok,
  input logic seen_q
);
  // R11
  gap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R2
  sof_not_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sof) |=> !out_valid);
  // R6
  hdr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hdr_ok |=> !out_valid);
  // R9
  seq_seen_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |=> seen_q);
endmodule

bind tcp_session_tap tcp_session_tap_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
  .out_valid(out_valid), .hdr_ok(hdr_ok), .seen_q(seen_q)
);

// File: tb/tcp_session_tap_bench.sv
module tcp_session_tap_bench;
  logic        clk = 0, rst_n = 0;
  logic [31:0] cfg_src_ip = 32'h0A000001, cfg_dst_ip = 32'h0A000002;
  logic [15:0] cfg_src_port = 16'd1234, cfg_dst_port = 16'd80;
  logic        cfg_seq_chk = 1;
  logic        in_valid = 0, in_sof = 0, in_eof = 0;
  logic [7:0]  in_byte = 0;
  logic        out_valid;
  logic [7:0]  out_data;

  int checks = 0, fails = 0, pay_lo = 0, pay_n = 0;
  logic [7:0] frm[$];
  logic [7:0] exp_q[$];
  string cur_tag = "R1";

  always #5 clk = ~clk;

  tcp_session_tap u_tcp_session_tap (.*);

  task automatic fail(input string tag, input string what, input int act, input int exp);
    fails++;
    $display("FAIL %s: %s actual=%0d expected=%0d", tag, what, act, exp);
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      checks++;
      if (exp_q.size() == 0) fail(cur_tag, "unexpected payload byte", out_data, -1);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        if (out_data != e) fail(cur_tag, "payload byte", out_data, e);
      end
    end
  end

  task automatic mk(input logic [15:0] etype, input int ihl, input logic [7:0] proto,
                    input logic [31:0] sip, input logic [31:0] dip,
                    input logic [15:0] sp, input logic [15:0] dp,
                    input logic [31:0] seq, input int doff, input int plen,
                    input int pad, input logic [7:0] seed);
    int tl;
    tl = ihl * 4 + doff * 4 + plen;
    frm.delete();
    for (int i = 0; i < 6; i++) frm.push_back(8'h02);
    for (int i = 0; i < 6; i++) frm.push_back(8'h04);
    frm.push_back(etype[15:8]); frm.push_back(etype[7:0]);
    frm.push_back({4'd4, 4'(ihl)}); frm.push_back(8'h00);
    frm.push_back(8'(tl >> 8)); frm.push_back(8'(tl));
    frm.push_back(8'h00); frm.push_back(8'h00); frm.push_back(8'h40); frm.push_back(8'h00);
    frm.push_back(8'd64); frm.push_back(proto); frm.push_back(8'h00); frm.push_back(8'h00);
    for (int i = 3; i >= 0; i--) frm.push_back(sip[i*8 +: 8]);
    for (int i = 3; i >= 0; i--) frm.push_back(dip[i*8 +: 8]);
    for (int i = 0; i < (ihl - 5) * 4; i++) frm.push_back(8'h00);
    frm.push_back(sp[15:8]); frm.push_back(sp[7:0]);
    frm.push_back(dp[15:8]); frm.push_back(dp[7:0]);
    for (int i = 3; i >= 0; i--) frm.push_back(seq[i*8 +: 8]);
    for (int i = 0; i < 4; i++) frm.push_back(8'h00);
    frm.push_back({4'(doff), 4'h0}); frm.push_back(8'h18);
    frm.push_back(8'hff); frm.push_back(8'hff);
    for (int i = 0; i < 4; i++) frm.push_back(8'h00);
    for (int i = 0; i < (doff - 5) * 4; i++) frm.push_back(8'h01);
    pay_lo = frm.size();
    pay_n  = plen;
    for (int i = 0; i < plen; i++) frm.push_back(seed + 8'(i));
    for (int i = 0; i < pad; i++) frm.push_back(8'h00);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      in_valid = 0; in_sof = 0; in_eof = 0;
    end
  endtask

  // nb = 0 sends the whole frame; with_eof marks the last byte sent
  task automatic send(input bit expect_it, input int nb, input bit with_eof, input bit gap);
    int n;
    n = (nb > 0) ? nb : frm.size();
    if (expect_it) for (int i = 0; i < pay_n; i++) exp_q.push_back(frm[pay_lo + i]);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      in_valid = 1; in_byte = frm[i];
      in_sof = (i == 0); in_eof = with_eof && (i == n - 1);
      if (gap && i != n - 1) idle(1);
    end
  endtask

  task automatic finish_scn(input string tag);
    idle(6);
    checks++;
    if (exp_q.size() != 0) fail(tag, "payload bytes missing", exp_q.size(), 0);
    exp_q.delete();
  endtask

  localparam logic [31:0] SIP = 32'h0A000001, DIP = 32'h0A000002;

  initial begin
    repeat (100000) @(posedge clk);
    fail("watchdog", "run timed out", 0, 1);
    $display("[TB] %0d tests run, %0d failed", checks + 1, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) fail("R1", "out_valid during reset", out_valid, 0);
    #1 rst_n = 1;
    idle(3);
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) fail("R1", "out_valid after reset", out_valid, 0);

    cur_tag = "R2";
    mk(16'h0800, 5, 8'd6, SIP, DIP, 16'd1234, 16'd80, 32'd1000, 5, 5, 0, 8'h10);
    send(1, 0, 1, 0); finish_scn("R2");

    cur_tag = "R3";
    mk(16'h86DD, 5, 8'd6, SIP, DIP, 16'd1234, 16'd80, 32'd1005, 5, 6, 0, 8'h20);
    send(0, 0, 1, 0); finish_scn("R3");

    cur_tag = "R4";
    mk(16'h0800, 5, 8'd17, SIP, DIP, 16'd1234, 16'd80, 32'd1005, 5, 6, 0, 8'h30);
    send(0, 0, 1, 0); finish_scn("R4");
    mk(16'h0800, 6, 8'd6, SIP, DIP, 16'd1234, 16'd80, 32'd1005, 5, 4, 0, 8'h40);
    send(1, 0, 1, 0); finish_scn("R4");

    cur_tag = "R5";
    mk(16'h0800, 5, 8'd6, SIP, DIP, 16'd1235, 16'd80, 32'd1009, 5, 4, 0, 8'h50);
    send(0, 0, 1, 0); finish_scn("R5");
    mk(16'h0800, 5, 8'd6, SIP, 32'h0A000003, 16'd1234, 16'd80, 32'd1009, 5, 4, 0, 8'h58);
    send(0, 0, 1, 0); finish_scn("R5");
    mk(16'h0800, 5, 8'd6, DIP, SIP, 16'd80, 16'd1234, 32'd1009, 5, 4, 0, 8'h5C);
    send(0, 0, 1, 0); finish_scn("R5");

    cur_tag = "R6";
    mk(16'h0800, 5, 8'd6, SIP, DIP, 16'd1234, 16'd80, 32'd1009, 8, 3, 0, 8'h60);
    send(1, 0, 1, 0); finish_scn("R6");

    cur_tag = "R7";
    mk(16'h0800, 5, 8'd6, SIP, DIP, 16'd1234, 16'd80, 32'd1012, 5, 2, 20, 8'h70);
    send(1, 0, 1, 0); finish_scn("R7");

    cur_tag = "R8";
    mk(16'h0800, 5, 8'd6, SIP, DIP, 16'd1234, 16'd80, 32'd1014, 5, 3, 0, 8'h80);
    send(0, 40, 1, 0); finish_scn("R8");
    mk(16'h0800, 5, 8'd6, SIP, DIP, 16'd1234, 16'd80, 32'd1014, 5, 3, 0, 8'h88);
    send(1, 0, 1, 0); finish_scn("R8");

    cur_tag = "R9";
    send(0, 0, 1, 0); finish_scn("R9");
    mk(16'h0800, 5, 8'd6, SIP, DIP, 16'd1234, 16'd80, 32'd2000, 5, 3, 0, 8'h90);
    send(0, 0, 1, 0); finish_scn("R9");
    mk(16'h0800, 5, 8'd6, SIP, DIP, 16'd1234, 16'd80, 32'd1017, 5, 2, 0, 8'h98);
    send(1, 0, 1, 0); finish_scn("R9");
    cfg_seq_chk = 0;
    mk(16'h0800, 5, 8'd6, SIP, DIP, 16'd1234, 16'd80, 32'd5000, 5, 3, 0, 8'hA0);
    send(1, 0, 1, 0); finish_scn("R9");

    cur_tag = "R10";
    mk(16'h0800, 5, 8'd6, SIP, DIP, 16'd1234, 16'd80, 32'd6000, 5, 3, 0, 8'hB0);
    send(0, 40, 0, 0);
    mk(16'h0800, 5, 8'd6, SIP, DIP, 16'd1234, 16'd80, 32'd6100, 5, 4, 0, 8'hB8);
    send(1, 0, 1, 0); finish_scn("R10");

    cur_tag = "R11";
    mk(16'h0800, 5, 8'd6, SIP, DIP, 16'd1234, 16'd80, 32'd7000, 5, 5, 0, 8'hC0);
    send(1, 0, 1, 1); finish_scn("R11");

    cur_tag = "R2 R9 back-to-back";
    cfg_seq_chk = 1;
    mk(16'h0800, 5, 8'd6, SIP, DIP, 16'd1234, 16'd80, 32'd7005, 5, 4, 0, 8'hD0);
    send(1, 0, 1, 0);
    mk(16'h0800, 5, 8'd6, SIP, DIP, 16'd1234, 16'd80, 32'd7009, 5, 3, 0, 8'hE0);
    send(1, 0, 1, 0);
    mk(16'h0800, 5, 8'd6, SIP, DIP, 16'd1234, 16'd80, 32'd7009, 5, 3, 0, 8'hF0);
    send(0, 0, 1, 0);
    finish_scn("R2 R9 back-to-back");

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule